// File: doc/BRIEF.md
# PLL Lock Status Unit

This unit decides whether a frequency synthesizer has settled on its programmed frequency. It samples the synthesizer's divided feedback signal in the reference clock domain, counts feedback edges over a fixed window of reference cycles, and compares the count with a target derived from the 3-bit multiplier setting. A live lock flag rises when the count comes close to the target. It falls again only when the count drifts much further away, so the flag has hysteresis. The live flag also gates the release of power-on reset.

Alongside the live flag the unit keeps a sticky lock-history flag. Lock after reset, or after a write that really changes the multiplier, sets this flag. Any later loss of lock clears it, and it stays clear through relocks. Stop mode preserves the flag. When fast wakeup is enabled, the flag is hidden after stop exit until the synthesizer has relocked. The unit presents both flags, together with a one-hot reference-source indication, in a read-only status byte.

Top module: `pll_lock_status`

## Requirements
- R1: Each window is 1024 reference cycles and the target is (multiplier+1)×32 feedback edges. While unlocked, the live flag (status bit 3) sets at a window end whose count is within ±7 of the target, and it never changes in the middle of a window.
- R2: While locked, the live flag stays set for any window count within ±15 of the target. It clears at the first window end whose count deviates by more than 15.
- R3: In modes 0 (normal) and 1 (one-to-one), the sticky flag (status bit 4) reads 0 after reset. It becomes 1 when the live flag first sets after reset.
- R4: Loss of the live flag outside stop clears the sticky flag. A later relock leaves the sticky flag at 0.
- R5: A multiplier write with a value that differs from the stored one clears both flags and restarts the window. The sticky flag then sets again at the next lock.
- R6: A multiplier write with the value already stored has no effect on either flag.
- R7: While the stop input is high, the sticky flag holds its value, even if the live flag drops. After stop exit without fast wakeup, the sticky flag still shows its pre-stop value.
- R8: On stop exit with fast wakeup high, the live flag restarts from 0 and the sticky flag reads 0 until the live flag sets again. After that, the sticky flag shows its pre-stop value.
- R9: With mode code 2 or 3 (external clock) latched at reset, status bits 4 and 3 stay 0 and the reset-release output is 1.
- R10: Status bits 7/6/5 are a one-hot decode of the source code latched at reset: code 2 sets bit 7 (external oscillator), code 1 sets bit 6 (on-chip oscillator), code 0 sets bit 5 (crystal), and code 3 sets none. Bits 2..0 read 0, and later changes of the source input have no effect.
- R11: In modes 0 and 1, the reset-release output equals the live lock flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all state is clocked here |
| rst_n | input | 1 | Synchronous active-low reset; latches mode and source codes |
| mode_sel | input | 2 | Clocking mode code: 0 normal, 1 one-to-one, 2/3 external clock |
| src_sel | input | 2 | Reference source code: 0 crystal, 1 on-chip, 2 external oscillator, 3 none |
| fb_clk_in | input | 1 | Divided feedback signal from the synthesizer (asynchronous) |
| mfd_wr | input | 1 | One-cycle write strobe for the multiplier field |
| mfd_wdata | input | 3 | Multiplier value carried by the write |
| stop_in | input | 1 | High while the chip is in stop mode |
| fwkup_en | input | 1 | Fast-wakeup option, sampled at stop exit |
| status_byte | output | 8 | Read-only status: sources [7:5], sticky [4], live [3], zeros [2:0] |
| por_release | output | 1 | Qualifier allowing power-on reset to be released |

## Verification
The assertions assume that the feedback signal toggles at less than half the reference rate, so the two-flop sampler sees every high and low phase. They also assume that the mode and source inputs matter only while reset is held. The stimulus produces feedback pulses from an accumulator clocked on the reference, at no more than one pulse every two cycles, and it changes mode and source only inside reset. Each rate setting is held for three windows, so at least one whole window is measured at the new rate before the flags are sampled.

// File: rtl/plllk_pkg.sv
package plllk_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_ONE2ONE = 2'b01,
        MODE_EXT     = 2'b10,
        MODE_EXT_ALT = 2'b11
    } clk_mode_e;

    typedef struct packed {
        logic       src_ext_osc;
        logic       src_onchip;
        logic       src_crystal;
        logic       sticky_lock;
        logic       live_lock;
        logic [2:0] unused_zero;
    } status_t;

    function automatic logic is_pll_mode(input clk_mode_e m);
        return (m == MODE_NORMAL) || (m == MODE_ONE2ONE);
    endfunction

    // returns {external oscillator, on-chip, crystal}
    function automatic logic [2:0] src_onehot(input logic [1:0] code);
        logic [2:0] r;
        case (code)
            2'd0:    r = 3'b001;
            2'd1:    r = 3'b010;
            2'd2:    r = 3'b100;
            default: r = 3'b000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/plllk_edge_sync.sv
module plllk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);
    localparam int SR_W = STAGES + 1;

    typedef struct packed {
        logic [SR_W-1:0] sr;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sr = {st_q.sr[SR_W-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // rising edge seen after the synchronizer stages
    assign edge_o = st_q.sr[STAGES-1] & ~st_q.sr[STAGES];

    // R1: one feedback pulse is never counted twice
    p_edge_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/plllk_freq_judge.sv
module plllk_freq_judge #(
    parameter int WIN_LOG2 = 10,
    parameter int CNT_W    = WIN_LOG2 + 1,
    parameter int ACQ_TOL  = 7,
    parameter int LOSS_TOL = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             locked_o
);
    localparam logic [WIN_LOG2-1:0] WIN_LAST = '1;
    localparam logic [CNT_W-1:0]    ACQ_T    = CNT_W'(ACQ_TOL);
    localparam logic [CNT_W-1:0]    LOSS_T   = CNT_W'(LOSS_TOL);

    typedef struct packed {
        logic [WIN_LOG2-1:0] win;
        logic [CNT_W-1:0]    cnt;
        logic                locked;
    } judge_st_t;

    judge_st_t st_d, st_q;
    logic [CNT_W-1:0] total, dev;
    logic             win_end;

    always_comb begin
        st_d    = st_q;
        total   = st_q.cnt + CNT_W'(edge_i);
        dev     = (total >= target_i) ? (total - target_i) : (target_i - total);
        win_end = (st_q.win == WIN_LAST) && enable && !restart;
        if (!enable || restart) begin
            st_d = '0;
        end else begin
            st_d.win = st_q.win + 1'b1;
            if (win_end) begin
                st_d.cnt = '0;
                if (st_q.locked) st_d.locked = (dev <= LOSS_T);
                else             st_d.locked = (dev <= ACQ_T);
            end else begin
                st_d.cnt = total;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked_o = st_q.locked;

    // R1: lock is only declared at a window boundary
    p_rise_at_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(win_end));

    // R2: the live flag cannot drop in the middle of a window
    p_hold_midwindow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !win_end && enable && !restart) |=> locked_o);

endmodule

// File: rtl/plllk_sticky_ctl.sv
module plllk_sticky_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_mode,
    input  logic mfd_chg,
    input  logic stop_i,
    input  logic fwkup_i,
    input  logic locked_i,
    output logic sticky_o,
    output logic wake_restart_o
);
    typedef struct packed {
        logic sticky;
        logic armed;
        logic waiting;
        logic stop_prev;
        logic locked_prev;
    } sticky_st_t;

    localparam sticky_st_t ST_RST = '{sticky: 1'b0, armed: 1'b1, waiting: 1'b0,
                                      stop_prev: 1'b0, locked_prev: 1'b0};

    sticky_st_t st_d, st_q;
    logic stop_fall, loss;

    always_comb begin
        st_d             = st_q;
        stop_fall        = st_q.stop_prev && !stop_i;
        wake_restart_o   = pll_mode && stop_fall && fwkup_i && !mfd_chg;
        loss             = st_q.locked_prev && !locked_i;
        st_d.stop_prev   = stop_i;
        st_d.locked_prev = locked_i && !mfd_chg && !wake_restart_o;

        if (!pll_mode) begin
            st_d.sticky  = 1'b0;
            st_d.armed   = 1'b0;
            st_d.waiting = 1'b0;
        end else if (mfd_chg) begin
            st_d.sticky  = 1'b0;
            st_d.armed   = 1'b1;
            st_d.waiting = 1'b0;
        end else if (stop_i) begin
            st_d.sticky  = st_q.sticky;
        end else if (wake_restart_o) begin
            st_d.waiting = 1'b1;
        end else if (st_q.waiting) begin
            if (locked_i) st_d.waiting = 1'b0;
        end else if (loss) begin
            st_d.sticky  = 1'b0;
            st_d.armed   = 1'b0;
        end else if (locked_i && st_q.armed) begin
            st_d.sticky  = 1'b1;
            st_d.armed   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign sticky_o = st_q.sticky && !st_q.waiting;

    // R3: history flag sets only from an armed state while locked
    p_set_needs_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sticky) |-> $past(locked_i && st_q.armed));

    // R4: an ordinary loss of lock clears the history flag
    p_loss_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_mode && loss && !stop_i && !st_q.waiting && !mfd_chg && !wake_restart_o)
        |=> !st_q.sticky);

    // R7: stop freezes the history flag
    p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_mode && stop_i && !mfd_chg) |=> $stable(st_q.sticky));

    // R8: fast-wakeup exit hides the history flag
    p_wake_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_restart_o |=> !sticky_o);

endmodule

// File: rtl/pll_lock_status.sv
module pll_lock_status #(
    parameter int WIN_LOG2  = 10,
    parameter int UNIT_LOG2 = 5,
    parameter int ACQ_TOL   = 7,
    parameter int LOSS_TOL  = 15,
    parameter int MFD_W     = 3,
    parameter int MFD_RST   = 3,
    parameter int SYNC_STG  = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic [1:0]       src_sel,
    input  logic             fb_clk_in,
    input  logic             mfd_wr,
    input  logic [MFD_W-1:0] mfd_wdata,
    input  logic             stop_in,
    input  logic             fwkup_en,
    output logic [7:0]       status_byte,
    output logic             por_release
);
    import plllk_pkg::*;

    localparam int CNT_W = WIN_LOG2 + 1;

    typedef struct packed {
        clk_mode_e        mode;
        logic [1:0]       src;
        logic [MFD_W-1:0] mfd;
    } cfg_st_t;

    cfg_st_t          cfg_d, cfg_q, cfg_rst;
    logic             pll_mode, mfd_chg, fb_edge, locked, sticky, wake_restart;
    logic [CNT_W-1:0] target;
    status_t          stat;

    always_comb begin
        cfg_d   = cfg_q;
        mfd_chg = mfd_wr && (mfd_wdata != cfg_q.mfd);
        if (mfd_wr) cfg_d.mfd = mfd_wdata;
        cfg_rst = '{mode: clk_mode_e'(mode_sel), src: src_sel, mfd: MFD_W'(MFD_RST)};
    end

    always_ff @(posedge ref_clk) begin
        if (!rst_n) cfg_q <= cfg_rst;
        else        cfg_q <= cfg_d;
    end

    assign pll_mode = is_pll_mode(cfg_q.mode);
    assign target   = (CNT_W'(cfg_q.mfd) + CNT_W'(1)) << UNIT_LOG2;

    plllk_edge_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .async_i (fb_clk_in),
        .edge_o  (fb_edge)
    );

    plllk_freq_judge #(
        .WIN_LOG2 (WIN_LOG2),
        .CNT_W    (CNT_W),
        .ACQ_TOL  (ACQ_TOL),
        .LOSS_TOL (LOSS_TOL)
    ) u_judge (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .enable   (pll_mode),
        .restart  (mfd_chg || wake_restart),
        .edge_i   (fb_edge),
        .target_i (target),
        .locked_o (locked)
    );

    plllk_sticky_ctl u_sticky (
        .clk            (ref_clk),
        .rst_n          (rst_n),
        .pll_mode       (pll_mode),
        .mfd_chg        (mfd_chg),
        .stop_i         (stop_in),
        .fwkup_i        (fwkup_en),
        .locked_i       (locked),
        .sticky_o       (sticky),
        .wake_restart_o (wake_restart)
    );

    always_comb begin
        {stat.src_ext_osc, stat.src_onchip, stat.src_crystal} = src_onehot(cfg_q.src);
        stat.sticky_lock = sticky;
        stat.live_lock   = locked;
        stat.unused_zero = 3'b000;
    end

    assign status_byte = stat;
    assign por_release = !pll_mode || locked;

    // R9: external clock mode never reports lock and never holds reset
    p_ext_flags_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !pll_mode |-> (status_byte[4:3] == 2'b00) && por_release);

    // R10: source field is one-hot or empty, low bits are zero
    p_layout_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $onehot0(status_byte[7:5]) && (status_byte[2:0] == 3'b000));

    // R10: source field does not follow the input after reset
    p_src_frozen_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(status_byte[7:5]));

    // R6: a rewrite of the same multiplier leaves the flags alone
    p_same_mfd_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (mfd_wr && !mfd_chg && !stop_in && pll_mode && $past(rst_n) &&
         (status_byte[4:3] == 2'b10)) |=> status_byte[4]);

    // R11: reset release follows live lock in PLL modes
    p_por_live_r11: assert property (@(posedge ref_clk) disable iff (!rst_n)
        pll_mode |-> (por_release == status_byte[3]));

endmodule

// File: tb/pll_lock_status_bench.sv
module pll_lock_status_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 1024;
    localparam int SETTLE     = 3 * WIN + 8;
    localparam int NVEC       = 9;

    typedef struct packed {
        logic       do_wr;
        logic [2:0] wr_val;
        logic [15:0] rate;
        logic       exp_live;
        logic       exp_sticky;
        logic [3:0] req;
    } vec_t;

    // walked in order from reset with multiplier 3 (target 128)
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'd0, 16'd148, 1'b0, 1'b0, 4'd1},  // R1 dev 20, no acquire
        '{1'b0, 3'd0, 16'd132, 1'b1, 1'b1, 4'd3},  // R3 acquire sets sticky
        '{1'b0, 3'd0, 16'd140, 1'b1, 1'b1, 4'd2},  // R2 dev 12 keeps lock
        '{1'b0, 3'd0, 16'd116, 1'b1, 1'b1, 4'd2},  // R2 dev -12 keeps lock
        '{1'b0, 3'd0, 16'd148, 1'b0, 1'b0, 4'd4},  // R4 loss clears sticky
        '{1'b0, 3'd0, 16'd140, 1'b0, 1'b0, 4'd1},  // R1 dev 12 no reacquire
        '{1'b0, 3'd0, 16'd128, 1'b1, 1'b0, 4'd4},  // R4 relock, sticky stays 0
        '{1'b1, 3'd3, 16'd128, 1'b1, 1'b0, 4'd6},  // R6 same value rewrite
        '{1'b1, 3'd5, 16'd192, 1'b1, 1'b1, 4'd5}   // R5 new value re-arms
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [1:0] src_sel = 2'd0;
    logic       fb = 1'b0;
    logic       mfd_wr = 1'b0;
    logic [2:0] mfd_wdata = 3'd0;
    logic       stop_in = 1'b0;
    logic       fwkup_en = 1'b0;
    logic [7:0] status_byte;
    logic       por_release;

    int checks = 0;
    int errors = 0;
    int rate   = 0;
    int acc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_lock_status u_pll_lock_status (
        .ref_clk     (clk),
        .rst_n       (rst_n),
        .mode_sel    (mode_sel),
        .src_sel     (src_sel),
        .fb_clk_in   (fb),
        .mfd_wr      (mfd_wr),
        .mfd_wdata   (mfd_wdata),
        .stop_in     (stop_in),
        .fwkup_en    (fwkup_en),
        .status_byte (status_byte),
        .por_release (por_release)
    );

    // feedback pulse generator: rate pulses per WIN reference cycles
    initial begin
        forever begin
            @(negedge clk);
            acc = acc + rate;
            if (acc >= WIN) begin
                acc = acc - WIN;
                fb  = 1'b1;
            end else begin
                fb  = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (por,status)", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] m, input logic [1:0] s);
        rst_n    = 1'b0;
        mode_sel = m;
        src_sel  = s;
        stop_in  = 1'b0;
        fwkup_en = 1'b0;
        mfd_wr   = 1'b0;
        wait_cyc(4);
        rst_n    = 1'b1;
        wait_cyc(1);
    endtask

    task automatic write_mfd(input logic [2:0] v);
        mfd_wdata = v;
        mfd_wr    = 1'b1;
        wait_cyc(1);
        mfd_wr    = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset state, normal mode, crystal source
        do_reset(2'd0, 2'd0);
        chk("R3 reset state", {por_release, status_byte}, 9'b0_0010_0000);
        src_sel = 2'd2;
        wait_cyc(3);
        chk("R10 source frozen after reset", {por_release, status_byte}, 9'b0_0010_0000);

        for (int i = 0; i < NVEC; i++) begin
            rate = int'(VECS[i].rate);
            if (VECS[i].do_wr) write_mfd(VECS[i].wr_val);
            wait_cyc(SETTLE);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), {por_release, status_byte},
                {VECS[i].exp_live, 3'b001, VECS[i].exp_sticky, VECS[i].exp_live, 3'b000});
        end

        // R5: a changing write clears both flags at once
        rate = 224;
        write_mfd(3'd6);
        wait_cyc(2);
        chk("R5 cleared after write", {por_release, status_byte}, 9'b0_0010_0000);
        wait_cyc(SETTLE);
        chk("R5 relock sets sticky", {por_release, status_byte}, 9'b1_0011_1000);

        // R7: stop with synthesizer off, no fast wakeup
        fwkup_en = 1'b0;
        stop_in  = 1'b1;
        rate     = 0;
        wait_cyc(SETTLE);
        chk("R7 sticky held in stop", {por_release, status_byte}, 9'b0_0011_0000);
        stop_in  = 1'b0;
        rate     = 224;
        wait_cyc(SETTLE);
        chk("R7 pre-stop value after exit", {por_release, status_byte}, 9'b1_0011_1000);

        // R8: stop exit with fast wakeup
        fwkup_en = 1'b1;
        stop_in  = 1'b1;
        wait_cyc(100);
        chk("R8 sticky during stop", {por_release, status_byte}, 9'b1_0011_1000);
        stop_in  = 1'b0;
        wait_cyc(3);
        chk("R8 masked after wake", {por_release, status_byte}, 9'b0_0010_0000);
        wait_cyc(SETTLE);
        chk("R8 restored after relock", {por_release, status_byte}, 9'b1_0011_1000);
        fwkup_en = 1'b0;

        // R9 / R10: external clock mode, external oscillator source
        rate = 128;
        do_reset(2'd2, 2'd2);
        wait_cyc(SETTLE);
        chk("R9 external mode flags", {por_release, status_byte}, 9'b1_1000_0000);

        // R9 / R10: alternate external code, no source
        do_reset(2'd3, 2'd3);
        wait_cyc(WIN + 8);
        chk("R10 empty source", {por_release, status_byte}, 9'b1_0000_0000);

        // R3 / R11: one-to-one mode, on-chip source
        do_reset(2'd1, 2'd1);
        chk("R11 reset release held low", {por_release, status_byte}, 9'b0_0100_0000);
        wait_cyc(SETTLE);
        chk("R3 one-to-one lock", {por_release, status_byte}, 9'b1_0101_1000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule